// File: doc/BRIEF.md
# Multi-Channel Join and Broadcast Handshake Controller

This controller sits at the edge of a locally clocked module that exchanges words with N neighbours, and each neighbour has a single port. On the receive side, the module raises a receive demand. The controller then asks for the local clock to be held and gathers the four-phase requests of all N senders. When every request is high, it raises one acknowledge that goes to all senders together and captures every sender's word on that same edge. The acknowledge is released only after every sender has withdrawn its request.

On the send side, a send demand places one word on a bus that all receivers share. The controller raises one request and keeps it up until every receiver has acknowledged. It then lowers the request and waits for every acknowledge to fall before it reports completion. A new offer is never made while any acknowledge is still high. Both sides join the channels with a logical AND of the per-channel handshake signals. There is no arbitration and no channel is served on its own. The busy state of each side is ORed into a single clock-stretch request.

All handshake inputs are taken to be already synchronous to `clk`.

Top module: `mpjb_hub`

## Requirements
- R1: While `rst` is high (synchronous, active high), `snd_ack`, `bus_req`, `rd_done`, `wr_done` and `stretch` are 0, and every captured word and `bus_data` are cleared to 0.
- R2: A cycle with `rd_demand` high while the receive side is idle starts a receive; `rd_demand` has no effect while a receive is in progress.
- R3: `snd_ack` rises on the edge after a cycle in which the receive side is gathering and all N bits of `snd_req` are high. It never rises otherwise.
- R4: On the edge where `snd_ack` rises, `rd_data` takes every sender's word, with channel i at bits [i*W +: W] of both `snd_data` and `rd_data`. At all other times `rd_data` holds its value.
- R5: `snd_ack` stays high while any bit of `snd_req` is high. It falls on the edge after a cycle with all bits low, and `rd_done` is high for exactly that one following cycle.
- R6: A cycle with `wr_demand` high while the send side is idle loads `wr_word` into `bus_data` on that edge. `bus_data` then holds until the next accepted send demand, and `wr_demand` has no effect while a send is in progress.
- R7: After a send demand is accepted, `bus_req` rises on the first edge after a cycle in which all `rcv_ack` bits are low. It stays high until a cycle in which all `rcv_ack` bits are high, and falls on the next edge.
- R8: After `bus_req` falls, the send side returns to idle on the edge after a cycle in which all `rcv_ack` bits are low. `wr_done` is high for exactly that one following cycle.
- R9: `stretch` is high exactly while either side is busy, that is, from the edge after the accepted demand until the edge on which that side's done pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_demand | input | 1 | Receive demand from the local logic |
| snd_req | input | N | Per-sender four-phase requests |
| snd_data | input | N*W | Per-sender words, channel i at [i*W +: W] |
| snd_ack | output | 1 | Joint acknowledge sent to all senders |
| rd_data | output | N*W | Captured words, channel i at [i*W +: W] |
| rd_done | output | 1 | One-cycle pulse when a receive completes |
| wr_demand | input | 1 | Send demand from the local logic |
| wr_word | input | W | Word to broadcast |
| bus_data | output | W | Broadcast bus shared by all receivers |
| bus_req | output | 1 | Broadcast request to all receivers |
| rcv_ack | input | N | Per-receiver acknowledges |
| wr_done | output | 1 | One-cycle pulse when a send completes |
| stretch | output | 1 | Combined clock-stretch request |

## Verification
The receive side and the send side run independently, so both can start in the same cycle and finish in the same cycle. When they overlap, the two done pulses, the falling acknowledge and the falling request can all change on one edge, and the combined stretch must stay high until both sides are idle.

The bench provokes this with a phase that raises both demands together and uses fast neighbour responses, so completions line up. In a second phase one receiver keeps a stale acknowledge high when a send starts. A behavioural reference model tracks both sides and is compared against every output once per cycle, so any coincidence that goes wrong shows up at once.

// File: rtl/mpjb_pkg.sv
package mpjb_pkg;

    typedef enum logic [1:0] {
        J_IDLE   = 2'd0,
        J_GATHER = 2'd1,
        J_HOLD   = 2'd2
    } join_st_e;

    typedef enum logic [1:0] {
        B_IDLE  = 2'd0,
        B_ARM   = 2'd1,
        B_OFFER = 2'd2,
        B_DRAIN = 2'd3
    } bc_st_e;

    typedef struct packed {
        logic busy;
        logic done;
    } side_stat_t;

    function automatic logic side_busy(input side_stat_t s);
        return s.busy;
    endfunction

endpackage

// File: rtl/mpjb_word_bank.sv
module mpjb_word_bank #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N*W-1:0] din,
    output logic [N*W-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_chan
        logic [W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)       word_q <= '0;
            else if (load) word_q <= din[i*W +: W];
        end
        assign dout[i*W +: W] = word_q;
    end
endmodule

// File: rtl/mpjb_join.sv
module mpjb_join
    import mpjb_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           demand,
    input  logic [N-1:0]   req,
    input  logic [N*W-1:0] din,
    output logic           ack,
    output logic [N*W-1:0] dout,
    output side_stat_t     stat
);
    join_st_e st_q, st_d;
    logic     done_q;
    logic     all_req, no_req, load;

    assign all_req = &req;
    assign no_req  = ~|req;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            J_IDLE:   if (demand) st_d = J_GATHER;
            J_GATHER: if (all_req) begin st_d = J_HOLD; load = 1'b1; end
            J_HOLD:   if (no_req) st_d = J_IDLE;
            default:  st_d = J_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= J_IDLE;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == J_HOLD) && no_req;
        end
    end

    mpjb_word_bank #(.N(N), .W(W)) u_bank (
        .clk (clk),
        .rst (rst),
        .load(load),
        .din (din),
        .dout(dout)
    );

    assign ack       = (st_q == J_HOLD);
    assign stat.busy = (st_q != J_IDLE);
    assign stat.done = done_q;

    // R3: acknowledge only after every request was seen high
    a_r3_ack_after_all: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(&req));
    // R5: acknowledge held while any request remains
    a_r5_ack_holds: assert property (@(posedge clk) disable iff (rst)
        (ack && |req) |=> ack);
    // R5: acknowledge drops only after all requests were low
    a_r5_ack_falls: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> $past(~|req));
    // R4: captured words move only with a rising acknowledge
    a_r4_words_hold: assert property (@(posedge clk) disable iff (rst)
        !$rose(ack) |-> $stable(dout));
endmodule

// File: rtl/mpjb_bcast.sv
module mpjb_bcast
    import mpjb_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         demand,
    input  logic [W-1:0] word,
    input  logic [N-1:0] ack,
    output logic         req,
    output logic [W-1:0] bus,
    output side_stat_t   stat
);
    bc_st_e       st_q, st_d;
    logic         done_q;
    logic [W-1:0] bus_q;
    logic         all_ack, no_ack;

    assign all_ack = &ack;
    assign no_ack  = ~|ack;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            B_IDLE:  if (demand)  st_d = B_ARM;
            B_ARM:   if (no_ack)  st_d = B_OFFER;
            B_OFFER: if (all_ack) st_d = B_DRAIN;
            B_DRAIN: if (no_ack)  st_d = B_IDLE;
            default: st_d = B_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= B_IDLE;
            done_q <= 1'b0;
            bus_q  <= '0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == B_DRAIN) && no_ack;
            if (st_q == B_IDLE && demand) bus_q <= word;
        end
    end

    assign req       = (st_q == B_OFFER);
    assign bus       = bus_q;
    assign stat.busy = (st_q != B_IDLE);
    assign stat.done = done_q;

    // R7: an offer starts only after all acknowledges were low
    a_r7_offer_when_clear: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(~|ack));
    // R7: request held until every receiver acknowledged
    a_r7_req_holds: assert property (@(posedge clk) disable iff (rst)
        (req && !(&ack)) |=> req);
    // R6: bus word steady while offered
    a_r6_bus_steady: assert property (@(posedge clk) disable iff (rst)
        req |-> $stable(bus));
    // R8: completion only after all acknowledges were low
    a_r8_done_after_clear: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(~|ack));
endmodule

// File: rtl/mpjb_hub.sv
module mpjb_hub
    import mpjb_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_demand,
    input  logic [N-1:0]   snd_req,
    input  logic [N*W-1:0] snd_data,
    output logic           snd_ack,
    output logic [N*W-1:0] rd_data,
    output logic           rd_done,
    input  logic           wr_demand,
    input  logic [W-1:0]   wr_word,
    output logic [W-1:0]   bus_data,
    output logic           bus_req,
    input  logic [N-1:0]   rcv_ack,
    output logic           wr_done,
    output logic           stretch
);
    side_stat_t rx_stat, tx_stat;

    mpjb_join #(.N(N), .W(W)) u_join (
        .clk   (clk),
        .rst   (rst),
        .demand(rd_demand),
        .req   (snd_req),
        .din   (snd_data),
        .ack   (snd_ack),
        .dout  (rd_data),
        .stat  (rx_stat)
    );

    mpjb_bcast #(.N(N), .W(W)) u_bcast (
        .clk   (clk),
        .rst   (rst),
        .demand(wr_demand),
        .word  (wr_word),
        .ack   (rcv_ack),
        .req   (bus_req),
        .bus   (bus_data),
        .stat  (tx_stat)
    );

    assign rd_done = rx_stat.done;
    assign wr_done = tx_stat.done;
    assign stretch = side_busy(rx_stat) | side_busy(tx_stat);

    // R9: any live handshake keeps the clock stretched
    a_r9_stretch_cover: assert property (@(posedge clk) disable iff (rst)
        (snd_ack || bus_req) |-> stretch);
    // R5 / R8: a done pulse never coincides with its own live handshake
    a_r5_done_clean: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> !snd_ack);
endmodule

// File: tb/sim_mpjb_hub.sv
module sim_mpjb_hub;
    localparam int N = 4;
    localparam int W = 8;
    localparam time PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           rd_demand = 1'b0;
    logic [N-1:0]   snd_req = '0;
    logic [N*W-1:0] snd_data = '0;
    logic           snd_ack;
    logic [N*W-1:0] rd_data;
    logic           rd_done;
    logic           wr_demand = 1'b0;
    logic [W-1:0]   wr_word = '0;
    logic [W-1:0]   bus_data;
    logic           bus_req;
    logic [N-1:0]   rcv_ack = '0;
    logic           wr_done;
    logic           stretch;

    always #(PERIOD/2) clk = ~clk;

    mpjb_hub #(.N(N), .W(W)) u0 (
        .clk(clk), .rst(rst), .rd_demand(rd_demand), .snd_req(snd_req),
        .snd_data(snd_data), .snd_ack(snd_ack), .rd_data(rd_data),
        .rd_done(rd_done), .wr_demand(wr_demand), .wr_word(wr_word),
        .bus_data(bus_data), .bus_req(bus_req), .rcv_ack(rcv_ack),
        .wr_done(wr_done), .stretch(stretch)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: phases as integers, words in a queue-like array
    int           rx_ph = 0;   // 0 idle, 1 waiting for all requests, 2 acknowledging
    int           tx_ph = 0;   // 0 idle, 1 waiting for clear acks, 2 offering, 3 draining
    logic [W-1:0] m_words [N];
    logic [W-1:0] m_bus = '0;
    bit           m_rdone = 0, m_wdone = 0;

    always @(posedge clk) begin
        if (rst) begin
            rx_ph = 0; tx_ph = 0; m_bus = '0; m_rdone = 0; m_wdone = 0;
            for (int i = 0; i < N; i++) m_words[i] = '0;
        end else begin
            m_rdone = 0;
            if (rx_ph == 0) begin
                if (rd_demand) rx_ph = 1;
            end else if (rx_ph == 1) begin
                if (snd_req == {N{1'b1}}) begin
                    rx_ph = 2;
                    for (int i = 0; i < N; i++) m_words[i] = snd_data[i*W +: W];
                end
            end else if (snd_req == '0) begin
                rx_ph = 0; m_rdone = 1;
            end
            m_wdone = 0;
            case (tx_ph)
                0: if (wr_demand) begin tx_ph = 1; m_bus = wr_word; end
                1: if (rcv_ack == '0) tx_ph = 2;
                2: if (rcv_ack == {N{1'b1}}) tx_ph = 3;
                default: if (rcv_ack == '0) begin tx_ph = 0; m_wdone = 1; end
            endcase
        end
    end

    task automatic compare_all();
        chk(snd_ack == (rx_ph == 2), "R3 R5 snd_ack", snd_ack, rx_ph == 2);
        for (int i = 0; i < N; i++)
            chk(rd_data[i*W +: W] == m_words[i], "R4 rd_data", rd_data[i*W +: W], m_words[i]);
        chk(rd_done == m_rdone, "R5 rd_done", rd_done, m_rdone);
        chk(bus_data == m_bus, "R6 bus_data", bus_data, m_bus);
        chk(bus_req == (tx_ph == 2), "R7 bus_req", bus_req, tx_ph == 2);
        chk(wr_done == m_wdone, "R8 wr_done", wr_done, m_wdone);
        chk(stretch == (rx_ph != 0 || tx_ph != 0), "R2 R9 stretch", stretch,
            rx_ph != 0 || tx_ph != 0);
    endtask

    logic [31:0] seed = 32'h1d2c3b4a;
    function automatic int rnd(input int n);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return int'(seed % n);
    endfunction

    bit stray = 0;

    task automatic drive_step(input int p_snd, input int p_rcv, input bit pair);
        for (int i = 0; i < N; i++) begin
            if (!snd_req[i] && !snd_ack && rnd(100) < p_snd) begin
                snd_req[i] = 1'b1;
                snd_data[i*W +: W] = W'(rnd(256));
            end else if (snd_req[i] && snd_ack && rnd(100) < p_snd) begin
                snd_req[i] = 1'b0;
            end
            if (bus_req && !rcv_ack[i] && rnd(100) < p_rcv) rcv_ack[i] = 1'b1;
            else if (!bus_req && rcv_ack[i] && !(stray && i == 0) && rnd(100) < p_rcv)
                rcv_ack[i] = 1'b0;
        end
        wr_word = W'(rnd(256));
        if (pair) begin
            rd_demand = (rnd(3) == 0);
            wr_demand = rd_demand;
        end else begin
            rd_demand = (rnd(4) == 0);
            wr_demand = (rnd(4) == 0);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(snd_ack == 0 && bus_req == 0 && stretch == 0, "R1 handshake outputs", {snd_ack, bus_req, stretch}, 0);
        chk(rd_data == '0 && bus_data == '0, "R1 words", rd_data, 0);
        chk(rd_done == 0 && wr_done == 0, "R1 done", {rd_done, wr_done}, 0);
        rst = 1'b0;

        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            compare_all();
            drive_step(30, 30, 1'b0);
        end
        // both sides started together with fast neighbours so completions coincide
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            compare_all();
            drive_step(80, 80, 1'b1);
        end
        // stale acknowledge held while a send starts (R7)
        repeat (40) begin
            @(negedge clk); compare_all();
            rd_demand = 0; wr_demand = 0;
            if (!stretch) break;
            drive_step(90, 90, 1'b0); rd_demand = 0; wr_demand = 0;
        end
        @(negedge clk); compare_all();
        rcv_ack = 4'b0001; stray = 1; wr_demand = 1; wr_word = 8'hA5;
        @(negedge clk); compare_all(); wr_demand = 0;
        repeat (5) begin
            @(negedge clk); compare_all();
            chk(bus_req == 0, "R7 no offer while ack stale", bus_req, 0);
        end
        chk(bus_data == 8'hA5, "R6 word loaded", bus_data, 8'hA5);
        rcv_ack = '0; stray = 0;
        @(negedge clk); compare_all();
        @(negedge clk); compare_all();
        chk(bus_req == 1, "R7 offer after clear", bus_req, 1);
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            compare_all();
            drive_step(50, 50, 1'b0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule